// File: doc/BRIEF.md
# Internal Error Reporting Aggregator

This block gathers internal error events for a multi-function endpoint or root port and turns them into per-function status and chip-level error strobes. The client logic raises a one-cycle correctable or uncorrectable strobe when it detects an internal fault. Such a fault belongs to no particular function, so the block records it in every function that is currently enabled. Each function can also report its own detected correctable, non-fatal and fatal events.

Each function holds a five-bit status word. For every error class, the block ORs together the unmasked class bits of all functions. The rising edge of that OR becomes a one-clock strobe on the matching class output, so a bit that stays set does not strobe again. In endpoint mode, a rising edge that comes from a function whose message enable is set also raises a one-clock message request, tagged with a class code. Software clears status bits one function at a time with a write-one-to-clear access.

Top module: `err_report_aggr`

## Requirements
- R1: After reset, every status bit, the three class strobes and the message request are 0.
- R2: A client correctable strobe sets bit 0 (correctable internal) and bit 2 (correctable detected) of every function whose enable is 1. Disabled functions do not change.
- R3: A client uncorrectable strobe sets bit 1 (uncorrectable internal) of every enabled function. It also sets bit 4 (fatal detected) if that function's severity input is 1, and bit 3 (non-fatal detected) otherwise.
- R4: A function's own correctable, non-fatal and fatal event inputs set bits 2, 3 and 4 of that function only, and only while it is enabled.
- R5: A status change is visible on the status output one cycle after the event. A class strobe (correctable on bit 2, non-fatal on bit 3, fatal on bit 4) goes high for exactly one cycle, one cycle after the OR across functions of that class's unmasked status bits rises.
- R6: While a class OR is already high, further functions or events setting that class produce no new strobe.
- R7: A class bit whose mask bit is 1 produces no strobe. Clearing the mask while the bit is still set raises the OR and produces a strobe.
- R8: A clear access (valid, function index, 5-bit clear pattern) clears exactly the chosen bits of the chosen function, and touches no other function.
- R9: When a set event and a clear of the same bit land in the same cycle, the bit ends up set.
- R10: In endpoint mode, the message request goes high for one cycle when the OR of unmasked class bits, taken over functions whose message enable is 1, rises. Its class code is 2 for fatal, 1 for non-fatal and 0 for correctable. When several classes rise together, the most severe one is reported.
- R11: With endpoint mode 0, no message request is raised, but the class strobes still behave as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ep_mode | input | 1 | 1 = endpoint mode, message requests allowed |
| fn_en | input | NUM_FN | Per-function enable |
| sev_fatal | input | NUM_FN | Per-function severity of uncorrectable internal errors (1 = fatal) |
| cor_mask | input | NUM_FN | Per-function correctable reporting mask |
| nf_mask | input | NUM_FN | Per-function non-fatal reporting mask |
| fatal_mask | input | NUM_FN | Per-function fatal reporting mask |
| msg_en | input | NUM_FN | Per-function message enable |
| client_cor_err | input | 1 | One-cycle client correctable strobe |
| client_unc_err | input | 1 | One-cycle client uncorrectable strobe |
| fn_cor_evt | input | NUM_FN | Per-function correctable event |
| fn_nf_evt | input | NUM_FN | Per-function non-fatal event |
| fn_fatal_evt | input | NUM_FN | Per-function fatal event |
| clr_valid | input | 1 | Write-one-to-clear access strobe |
| clr_fn | input | FN_IDX_W | Function targeted by the clear |
| clr_bits | input | 5 | Bits to clear in that function |
| status | output | NUM_FN*5 | Status words, function f at bits [5f+4:5f] |
| cor_err_pulse | output | 1 | Correctable class strobe |
| nonfatal_err_pulse | output | 1 | Non-fatal class strobe |
| fatal_err_pulse | output | 1 | Fatal class strobe |
| msg_req | output | 1 | One-cycle error message request |
| msg_class | output | 2 | Class of the requested message |

## Verification
Some properties are checked by assertions on every cycle. A set bit wins over a clear of the same bit. A clear with no set removes the chosen bits. A disabled function never gains a bit. No strobe lasts two cycles. A message request needs endpoint mode and some message enable in the previous cycle. Other behaviour can only be shown by the bench's scenarios, which sweep the enable, severity, mask and message-enable patterns against a model. These are the fan-out of client strobes to exactly the enabled functions, the choice between fatal and non-fatal by severity, strobe suppression while a class OR stays high, the strobe caused by unmasking, and the message class priority.

// File: rtl/err_aggr_pkg.sv
package err_aggr_pkg;
  localparam int STS_W        = 5;
  localparam int STS_COR_INT  = 0;
  localparam int STS_UNC_INT  = 1;
  localparam int STS_COR_DET  = 2;
  localparam int STS_NF_DET   = 3;
  localparam int STS_FAT_DET  = 4;

  localparam int CLS_W        = 3;
  localparam int CLS_COR      = 0;
  localparam int CLS_NF       = 1;
  localparam int CLS_FAT      = 2;

  typedef enum logic [1:0] {
    MSG_COR      = 2'd0,
    MSG_NONFATAL = 2'd1,
    MSG_FATAL    = 2'd2
  } msg_class_e;
endpackage

// File: rtl/aggr_fn_status.sv
module aggr_fn_status
  import err_aggr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             fn_en,
  input  logic             sev_fatal,
  input  logic             client_cor,
  input  logic             client_unc,
  input  logic             evt_cor,
  input  logic             evt_nf,
  input  logic             evt_fatal,
  input  logic             clr_hit,
  input  logic [STS_W-1:0] clr_bits,
  output logic [STS_W-1:0] sts
);
  logic [STS_W-1:0] set_v;
  logic [STS_W-1:0] clr_v;
  logic [STS_W-1:0] sts_q;

  always_comb begin
    set_v = '0;
    if (fn_en) begin
      set_v[STS_COR_INT] = client_cor;
      set_v[STS_UNC_INT] = client_unc;
      set_v[STS_COR_DET] = client_cor | evt_cor;
      set_v[STS_NF_DET]  = (client_unc & ~sev_fatal) | evt_nf;
      set_v[STS_FAT_DET] = (client_unc & sev_fatal) | evt_fatal;
    end
  end

  assign clr_v = clr_hit ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) sts_q <= '0;
    else     sts_q <= (sts_q & ~clr_v) | set_v;
  end

  assign sts = sts_q;

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (set_v != '0) |=> ((sts_q & $past(set_v)) == $past(set_v)));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_hit |=> ((sts_q & $past(clr_bits) & ~$past(set_v)) == '0));

  // R2
  disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fn_en |=> ((sts_q & ~$past(sts_q)) == '0));
endmodule

// File: rtl/aggr_class_reduce.sv
module aggr_class_reduce
  import err_aggr_pkg::*;
#(
  parameter int NUM_FN = 4
) (
  input  logic [NUM_FN*STS_W-1:0] sts_flat,
  input  logic [NUM_FN-1:0]       cor_mask,
  input  logic [NUM_FN-1:0]       nf_mask,
  input  logic [NUM_FN-1:0]       fatal_mask,
  input  logic [NUM_FN-1:0]       msg_en,
  input  logic                    ep_mode,
  output logic [CLS_W-1:0]        cls_lvl,
  output logic [CLS_W-1:0]        msg_lvl
);
  logic [CLS_W-1:0] fn_cls [NUM_FN];

  for (genvar f = 0; f < NUM_FN; f++) begin : g_fn
    assign fn_cls[f][CLS_COR] = sts_flat[f*STS_W + STS_COR_DET] & ~cor_mask[f];
    assign fn_cls[f][CLS_NF]  = sts_flat[f*STS_W + STS_NF_DET]  & ~nf_mask[f];
    assign fn_cls[f][CLS_FAT] = sts_flat[f*STS_W + STS_FAT_DET] & ~fatal_mask[f];
  end

  always_comb begin
    cls_lvl = '0;
    msg_lvl = '0;
    for (int f = 0; f < NUM_FN; f++) begin
      cls_lvl = cls_lvl | fn_cls[f];
      if (msg_en[f]) msg_lvl = msg_lvl | fn_cls[f];
    end
    if (!ep_mode) msg_lvl = '0;
  end
endmodule

// File: rtl/aggr_edge_pulse.sv
module aggr_edge_pulse #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] pulse
);
  logic [W-1:0] prev_q;
  logic [W-1:0] pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      pulse_q <= '0;
    end else begin
      prev_q  <= lvl;
      pulse_q <= lvl & ~prev_q;
    end
  end

  assign pulse = pulse_q;

  // R5
  single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse_q != '0) |=> ((pulse_q & $past(pulse_q)) == '0));
endmodule

// File: rtl/err_report_aggr.sv
module err_report_aggr
  import err_aggr_pkg::*;
#(
  parameter  int NUM_FN   = 4,
  localparam int FN_IDX_W = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ep_mode,
  input  logic [NUM_FN-1:0]       fn_en,
  input  logic [NUM_FN-1:0]       sev_fatal,
  input  logic [NUM_FN-1:0]       cor_mask,
  input  logic [NUM_FN-1:0]       nf_mask,
  input  logic [NUM_FN-1:0]       fatal_mask,
  input  logic [NUM_FN-1:0]       msg_en,
  input  logic                    client_cor_err,
  input  logic                    client_unc_err,
  input  logic [NUM_FN-1:0]       fn_cor_evt,
  input  logic [NUM_FN-1:0]       fn_nf_evt,
  input  logic [NUM_FN-1:0]       fn_fatal_evt,
  input  logic                    clr_valid,
  input  logic [FN_IDX_W-1:0]     clr_fn,
  input  logic [STS_W-1:0]        clr_bits,
  output logic [NUM_FN*STS_W-1:0] status,
  output logic                    cor_err_pulse,
  output logic                    nonfatal_err_pulse,
  output logic                    fatal_err_pulse,
  output logic                    msg_req,
  output logic [1:0]              msg_class
);
  logic [NUM_FN*STS_W-1:0] sts_flat;
  logic [CLS_W-1:0]        cls_lvl;
  logic [CLS_W-1:0]        msg_lvl;
  logic [CLS_W-1:0]        cls_pulse;
  logic [CLS_W-1:0]        msg_pulse;
  msg_class_e              msg_cls;

  for (genvar f = 0; f < NUM_FN; f++) begin : g_fn
    aggr_fn_status u_sts (
      .clk        (clk),
      .rst        (rst),
      .fn_en      (fn_en[f]),
      .sev_fatal  (sev_fatal[f]),
      .client_cor (client_cor_err),
      .client_unc (client_unc_err),
      .evt_cor    (fn_cor_evt[f]),
      .evt_nf     (fn_nf_evt[f]),
      .evt_fatal  (fn_fatal_evt[f]),
      .clr_hit    (clr_valid && (clr_fn == FN_IDX_W'(f))),
      .clr_bits   (clr_bits),
      .sts        (sts_flat[f*STS_W +: STS_W])
    );
  end

  aggr_class_reduce #(.NUM_FN(NUM_FN)) u_reduce (
    .sts_flat   (sts_flat),
    .cor_mask   (cor_mask),
    .nf_mask    (nf_mask),
    .fatal_mask (fatal_mask),
    .msg_en     (msg_en),
    .ep_mode    (ep_mode),
    .cls_lvl    (cls_lvl),
    .msg_lvl    (msg_lvl)
  );

  aggr_edge_pulse #(.W(CLS_W)) u_cls_edge (
    .clk   (clk),
    .rst   (rst),
    .lvl   (cls_lvl),
    .pulse (cls_pulse)
  );

  aggr_edge_pulse #(.W(CLS_W)) u_msg_edge (
    .clk   (clk),
    .rst   (rst),
    .lvl   (msg_lvl),
    .pulse (msg_pulse)
  );

  always_comb begin
    if (msg_pulse[CLS_FAT])     msg_cls = MSG_FATAL;
    else if (msg_pulse[CLS_NF]) msg_cls = MSG_NONFATAL;
    else                        msg_cls = MSG_COR;
  end

  assign status             = sts_flat;
  assign cor_err_pulse      = cls_pulse[CLS_COR];
  assign nonfatal_err_pulse = cls_pulse[CLS_NF];
  assign fatal_err_pulse    = cls_pulse[CLS_FAT];
  assign msg_req            = |msg_pulse;
  assign msg_class          = msg_cls;

  // R11
  msg_mode_chk: assert property (@(posedge clk) disable iff (rst)
    msg_req |-> $past(ep_mode));

  // R10
  msg_enable_chk: assert property (@(posedge clk) disable iff (rst)
    msg_req |-> ($past(msg_en) != '0));
endmodule

// File: tb/err_report_aggr_bench.sv
`timescale 1ns/1ps
module err_report_aggr_bench;
  localparam int N  = 4;
  localparam int SW = 5;

  logic clk = 0;
  logic rst = 1;
  logic ep_mode = 0;
  logic [N-1:0] fn_en = 0, sev_fatal = 0, cor_mask = 0, nf_mask = 0, fatal_mask = 0, msg_en = 0;
  logic client_cor_err = 0, client_unc_err = 0;
  logic [N-1:0] fn_cor_evt = 0, fn_nf_evt = 0, fn_fatal_evt = 0;
  logic clr_valid = 0;
  logic [1:0] clr_fn = 0;
  logic [SW-1:0] clr_bits = 0;
  logic [N*SW-1:0] status;
  logic cor_err_pulse, nonfatal_err_pulse, fatal_err_pulse, msg_req;
  logic [1:0] msg_class;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";

  logic [SW-1:0] m_sts [N];
  logic [2:0] m_prev = 0, m_pulse = 0, m_mprev = 0, m_mpulse = 0;

  err_report_aggr #(.NUM_FN(N)) u_err_report_aggr (.*);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [N*SW-1:0] model_flat();
    logic [N*SW-1:0] v;
    for (int f = 0; f < N; f++) v[f*SW +: SW] = m_sts[f];
    return v;
  endfunction

  task automatic tick();
    logic [2:0] lvl = 0, mlvl = 0, c;
    logic [SW-1:0] nsts [N];
    logic [SW-1:0] set, clr;
    logic [1:0] ecls;
    for (int f = 0; f < N; f++) begin
      c = {m_sts[f][4] & ~fatal_mask[f], m_sts[f][3] & ~nf_mask[f], m_sts[f][2] & ~cor_mask[f]};
      lvl |= c;
      if (msg_en[f]) mlvl |= c;
      set = 0;
      if (fn_en[f]) begin
        set[0] = client_cor_err;
        set[1] = client_unc_err;
        set[2] = client_cor_err | fn_cor_evt[f];
        set[3] = (client_unc_err & ~sev_fatal[f]) | fn_nf_evt[f];
        set[4] = (client_unc_err & sev_fatal[f]) | fn_fatal_evt[f];
      end
      clr = (clr_valid && clr_fn == 2'(f)) ? clr_bits : '0;
      nsts[f] = (m_sts[f] & ~clr) | set;
    end
    if (!ep_mode) mlvl = 0;
    @(posedge clk);
    for (int f = 0; f < N; f++) m_sts[f] = nsts[f];
    m_pulse  = lvl & ~m_prev;
    m_prev   = lvl;
    m_mpulse = mlvl & ~m_mprev;
    m_mprev  = mlvl;
    @(negedge clk);
    chk(status == model_flat(), cur_req, 32'(status), 32'(model_flat()));
    chk({fatal_err_pulse, nonfatal_err_pulse, cor_err_pulse} == m_pulse, cur_req,
        32'({fatal_err_pulse, nonfatal_err_pulse, cor_err_pulse}), 32'(m_pulse));
    chk(msg_req == (m_mpulse != 0), cur_req, 32'(msg_req), 32'(m_mpulse != 0));
    ecls = m_mpulse[2] ? 2'd2 : (m_mpulse[1] ? 2'd1 : 2'd0);
    if (msg_req && m_mpulse != 0) chk(msg_class == ecls, cur_req, 32'(msg_class), 32'(ecls));
    client_cor_err = 0; client_unc_err = 0;
    fn_cor_evt = 0; fn_nf_evt = 0; fn_fatal_evt = 0;
    clr_valid = 0;
  endtask

  task automatic clear_all();
    for (int f = 0; f < N; f++) begin
      clr_valid = 1; clr_fn = 2'(f); clr_bits = '1;
      tick();
    end
    tick();
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int f = 0; f < N; f++) m_sts[f] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(status == 0, "R1", 32'(status), 0);
    chk({fatal_err_pulse, nonfatal_err_pulse, cor_err_pulse, msg_req} == 0, "R1",
        32'({fatal_err_pulse, nonfatal_err_pulse, cor_err_pulse, msg_req}), 0);

    // R2: client correctable fans out to enabled functions
    cur_req = "R2";
    for (int en = 0; en < 16; en++) begin
      fn_en = 4'(en); client_cor_err = 1; tick(); tick(); clear_all();
    end

    // R3: client uncorrectable with severity split
    cur_req = "R3";
    for (int en = 0; en < 16; en++)
      for (int sv = 0; sv < 16; sv++) begin
        fn_en = 4'(en); sev_fatal = 4'(sv); client_unc_err = 1; tick(); tick(); clear_all();
      end

    // R4: per-function events
    cur_req = "R4";
    for (int e = 0; e < 2; e++)
      for (int f = 0; f < N; f++)
        for (int ev = 1; ev < 8; ev++) begin
          fn_en = e ? 4'hF : ~(4'b1 << f);
          fn_cor_evt[f] = ev[0]; fn_nf_evt[f] = ev[1]; fn_fatal_evt[f] = ev[2];
          tick(); tick(); clear_all();
        end
    fn_en = 4'hF;

    // R5/R6: one strobe per rise, none while OR stays high
    cur_req = "R5";
    fn_fatal_evt[1] = 1; tick(); tick();
    chk(fatal_err_pulse == 1, "R5", 32'(fatal_err_pulse), 1);
    tick();
    chk(fatal_err_pulse == 0, "R5", 32'(fatal_err_pulse), 0);
    cur_req = "R6";
    fn_fatal_evt[3] = 1; tick(); tick();
    chk(fatal_err_pulse == 0, "R6", 32'(fatal_err_pulse), 0);
    fn_fatal_evt[1] = 1; tick(); tick(); tick();
    chk(fatal_err_pulse == 0, "R6", 32'(fatal_err_pulse), 0);
    clear_all();

    // R7: masking and unmasking
    cur_req = "R7";
    cor_mask = 4'hF; nf_mask = 4'hF;
    client_cor_err = 1; fn_nf_evt[2] = 1; tick(); tick(); tick();
    chk({nonfatal_err_pulse, cor_err_pulse} == 0, "R7", 32'({nonfatal_err_pulse, cor_err_pulse}), 0);
    cor_mask = 4'hE; tick(); tick();
    chk(cor_err_pulse == 0, "R7", 32'(cor_err_pulse), 0);
    nf_mask = 4'hB; tick();
    chk(nonfatal_err_pulse == 1, "R7", 32'(nonfatal_err_pulse), 1);
    tick(); clear_all();
    cor_mask = 0; nf_mask = 0;

    // R8: selective write-one-to-clear
    cur_req = "R8";
    for (int f = 0; f < N; f++)
      for (int b = 0; b < 32; b++) begin
        sev_fatal = 4'b0101; client_cor_err = 1; client_unc_err = 1;
        fn_nf_evt = 4'hF; fn_fatal_evt = 4'hF; tick();
        clr_valid = 1; clr_fn = 2'(f); clr_bits = 5'(b); tick();
        chk(status[f*SW +: SW] == (5'h1F & ~5'(b)), "R8", 32'(status[f*SW +: SW]), 32'(5'h1F & ~5'(b)));
        clear_all();
      end

    // R9: set beats clear
    cur_req = "R9";
    fn_cor_evt[2] = 1; clr_valid = 1; clr_fn = 2; clr_bits = 5'h1F; tick();
    chk(status[2*SW + 2] == 1, "R9", 32'(status[2*SW + 2]), 1);
    client_unc_err = 1; clr_valid = 1; clr_fn = 0; clr_bits = 5'h02; tick();
    chk(status[1] == 1, "R9", 32'(status[1]), 1);
    tick(); clear_all();

    // R10: messages in endpoint mode
    cur_req = "R10";
    ep_mode = 1; fatal_mask = 4'b0100; sev_fatal = 0;
    for (int me = 0; me < 16; me++)
      for (int f = 0; f < N; f++)
        for (int ev = 1; ev < 8; ev++) begin
          msg_en = 4'(me);
          fn_cor_evt[f] = ev[0]; fn_nf_evt[f] = ev[1]; fn_fatal_evt[f] = ev[2];
          tick(); tick(); clear_all();
        end
    msg_en = 4'b0001; fn_fatal_evt[0] = 1; fn_cor_evt[0] = 1; tick(); tick();
    chk(msg_req == 1 && msg_class == 2'd2, "R10", 32'({msg_req, msg_class}), 32'(3'b110));
    clear_all();

    // R11: no messages outside endpoint mode
    cur_req = "R11";
    ep_mode = 0; msg_en = 4'hF; fatal_mask = 0;
    for (int f = 0; f < N; f++)
      for (int ev = 1; ev < 8; ev++) begin
        fn_cor_evt[f] = ev[0]; fn_nf_evt[f] = ev[1]; fn_fatal_evt[f] = ev[2];
        tick(); tick();
        chk(msg_req == 0, "R11", 32'(msg_req), 0);
        clear_all();
      end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule